// File: doc/BRIEF.md
# Connection Memory Block Fill Sequencer

This block sits beside a time-slot switch's connection memory and, on command, overwrites every word of that memory with one programmed value. Each word is 12 bits. The sequencer places a 3-bit pattern in the low bits of the word and zeroes the rest. It visits the 16 streams x 128 channels (2048 words) one word per granted memory cycle. It presents a registered write strobe, address and data to the memory arbiter. The arbiter answers with a grant in any cycle it accepts the write.

Software starts a fill by raising both a fill-enable bit and a fill-go bit. Dropping either bit stops the fill at once, even part way through. While a fill runs, and until the go bit has been returned low, a lock output tells the host port that its normal accesses to the connection memory must be held off. A done flag marks a complete fill and stays up until software drops the go bit.

Top module: `cm_block_init`

## Requirements
- R1: While reset is high and in the cycle after reset, cm_wr_en, fill_done and host_lock are 0, and cm_wr_addr and cm_wr_data are 0.
- R2: A fill starts only when blk_en and blk_go are both 1 at a clock edge in the idle state. Either bit alone leaves cm_wr_en at 0. The first write is presented in the next cycle at address 0.
- R3: Each presented word carries the pattern in bits 2..0, and bits 11..3 are 0.
- R4: The address advances by exactly one only after an edge where cm_wr_en and mem_grant are both 1 and the fill is still enabled. Otherwise the same write stays presented. The address is {stream[3:0], channel[6:0]}, so stream is in bits 10..7, channel in bits 6..0, and the order is ascending.
- R5: Once the write to address 2047 is granted, cm_wr_en falls and fill_done rises in the next cycle. A full fill makes exactly 2048 granted writes.
- R6: fill_done stays 1 while blk_go is 1. It falls, together with host_lock, in the cycle after blk_go is seen at 0.
- R7: If blk_en or blk_go is 0 at an edge during a fill, cm_wr_en is 0 from the next cycle, no further write is presented, and fill_done stays 0.
- R8: After a fill has stopped with blk_go still 1, host_lock stays 1 and no new fill starts, even if blk_en is raised again. This holds until blk_go has been seen at 0.
- R9: host_lock is 1 in every cycle in which cm_wr_en is 1. It falls in the cycle after a stop in which blk_go is also 0.
- R10: The pattern is captured when the fill starts. Changing fill_pat during a fill does not change the words written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Fill-enable control bit |
| blk_go | input | 1 | Fill-go control bit |
| fill_pat | input | 3 | Pattern for the low bits of each word |
| mem_grant | input | 1 | Memory accepts the presented write this cycle |
| cm_wr_en | output | 1 | Write strobe to the connection memory |
| cm_wr_addr | output | 11 | Word address {stream, channel} |
| cm_wr_data | output | 12 | Word to write |
| fill_done | output | 1 | Full fill completed |
| host_lock | output | 1 | Hold off normal host access to the memory |

## Verification
The bench stalls the grant in irregular patterns. A design that advanced the address without a grant would skip words, and one that ignored the grant on the last word would raise done early or late. It stops fills through each control bit separately. After a stop through the enable bit it raises enable again while go is still high: a design that restarted there would rewrite the memory before software had acknowledged the stop. It also changes the pattern in the middle of a fill and counts granted writes over complete fills, which catches sequencers that sample the pattern live or wrap one word too early.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    CBI_IDLE = 2'd0,
    CBI_RUN  = 2'd1,
    CBI_HOLD = 2'd2
  } cbi_state_e;
endpackage

// File: rtl/cbi_addr_gen.sv
// Word address generator: {stream, channel}, ascending order.
module cbi_addr_gen #(
  parameter int STREAMS  = 16,
  parameter int CHANNELS = 128
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         clr,
  input  logic                                         step,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0]  addr,
  output logic                                         at_last
);
  localparam int SW = $clog2(STREAMS);
  localparam int CW = $clog2(CHANNELS);
  localparam int AW = SW + CW;
  localparam logic [SW-1:0] S_LAST = SW'(STREAMS - 1);
  localparam logic [CW-1:0] C_LAST = CW'(CHANNELS - 1);
  localparam bit FLAT = ((1 << SW) == STREAMS) && ((1 << CW) == CHANNELS);

  generate
    if (FLAT) begin : g_flat
      // Both dimensions are powers of two: one binary counter covers the map.
      logic [AW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
      end
      assign addr    = cnt;
      assign at_last = (cnt == {S_LAST, C_LAST});
    end else begin : g_nested
      // Channel counter wraps early and carries into the stream counter.
      logic [SW-1:0] s_cnt;
      logic [CW-1:0] c_cnt;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          s_cnt <= '0;
          c_cnt <= '0;
        end else if (step) begin
          if (c_cnt == C_LAST) begin
            c_cnt <= '0;
            s_cnt <= s_cnt + 1'b1;
          end else begin
            c_cnt <= c_cnt + 1'b1;
          end
        end
      end
      assign addr    = {s_cnt, c_cnt};
      assign at_last = (s_cnt == S_LAST) && (c_cnt == C_LAST);
    end
  endgenerate
endmodule

// File: rtl/cbi_word_fmt.sv
// Captures the pattern at fill start and builds the memory word.
module cbi_word_fmt #(
  parameter int WORD_W = 12,
  parameter int PAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAT_W-1:0]  pat,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] nxt;

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b < PAT_W) begin : g_pat
        assign nxt[b] = pat[b];
      end else begin : g_zero
        assign nxt[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       word <= '0;
    else if (load) word <= nxt;
  end
endmodule

// File: rtl/cbi_ctrl.sv
// Fill sequencing state machine with registered strobe, done and lock.
module cbi_ctrl
  import cbi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic go,
  input  logic grant,
  input  logic at_last,
  output logic load,
  output logic step,
  output logic wr_en,
  output logic done,
  output logic lock
);
  cbi_state_e state;
  logic       trig;

  assign trig = en & go;
  assign load = (state == CBI_IDLE) & trig;
  assign step = (state == CBI_RUN) & trig & grant & ~at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CBI_IDLE;
      wr_en <= 1'b0;
      done  <= 1'b0;
      lock  <= 1'b0;
    end else begin
      unique case (state)
        CBI_IDLE: begin
          if (trig) begin
            state <= CBI_RUN;
            wr_en <= 1'b1;
            lock  <= 1'b1;
          end
        end
        CBI_RUN: begin
          if (!trig) begin
            wr_en <= 1'b0;
            if (go) begin
              state <= CBI_HOLD;
            end else begin
              state <= CBI_IDLE;
              lock  <= 1'b0;
            end
          end else if (grant && at_last) begin
            wr_en <= 1'b0;
            done  <= 1'b1;
            state <= CBI_HOLD;
          end
        end
        CBI_HOLD: begin
          if (!go) begin
            state <= CBI_IDLE;
            done  <= 1'b0;
            lock  <= 1'b0;
          end
        end
        default: begin
          state <= CBI_IDLE;
          wr_en <= 1'b0;
          done  <= 1'b0;
          lock  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cm_block_init.sv
// Connection memory block fill sequencer (top).
module cm_block_init #(
  parameter int STREAMS  = 16,
  parameter int CHANNELS = 128,
  parameter int WORD_W   = 12,
  parameter int PAT_W    = 3
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        blk_en,
  input  logic                                        blk_go,
  input  logic [PAT_W-1:0]                            fill_pat,
  input  logic                                        mem_grant,
  output logic                                        cm_wr_en,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0] cm_wr_addr,
  output logic [WORD_W-1:0]                           cm_wr_data,
  output logic                                        fill_done,
  output logic                                        host_lock
);
  logic load, step, at_last;

  cbi_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (blk_en),
    .go      (blk_go),
    .grant   (mem_grant),
    .at_last (at_last),
    .load    (load),
    .step    (step),
    .wr_en   (cm_wr_en),
    .done    (fill_done),
    .lock    (host_lock)
  );

  cbi_addr_gen #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .step    (step),
    .addr    (cm_wr_addr),
    .at_last (at_last)
  );

  cbi_word_fmt #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_word (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .pat  (fill_pat),
    .word (cm_wr_data)
  );
endmodule

// File: rtl/cm_block_init_chk.sv
// Property checker bound to the fill sequencer.
module cm_block_init_chk #(
  parameter int AW     = 11,
  parameter int WORD_W = 12,
  parameter int PAT_W  = 3,
  parameter int TOTAL  = 2048
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_en,
  input logic              blk_go,
  input logic              mem_grant,
  input logic              cm_wr_en,
  input logic [AW-1:0]     cm_wr_addr,
  input logic [WORD_W-1:0] cm_wr_data,
  input logic              fill_done,
  input logic              host_lock
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);
  logic trig;
  assign trig = blk_en & blk_go;

  a_r2_no_write_without_trigger: assert property (@(posedge clk) disable iff (rst)
    (!trig && !cm_wr_en) |=> !cm_wr_en);

  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    cm_wr_en |-> (cm_wr_data[WORD_W-1:PAT_W] == '0));

  a_r4_hold_without_grant: assert property (@(posedge clk) disable iff (rst)
    (cm_wr_en && !mem_grant && trig) |=> (cm_wr_en && $stable(cm_wr_addr)));

  a_r4_step_on_grant: assert property (@(posedge clk) disable iff (rst)
    (cm_wr_en && mem_grant && trig && cm_wr_addr != LAST) |=>
      (cm_wr_en && cm_wr_addr == $past(cm_wr_addr) + 1'b1));

  a_r5_finish_on_last: assert property (@(posedge clk) disable iff (rst)
    (cm_wr_en && mem_grant && trig && cm_wr_addr == LAST) |=> (!cm_wr_en && fill_done));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
    (fill_done && !blk_go) |=> (!fill_done && !host_lock));

  a_r7_stop_drops_strobe: assert property (@(posedge clk) disable iff (rst)
    (cm_wr_en && !trig) |=> (!cm_wr_en && !fill_done));

  a_r8_no_restart_in_hold: assert property (@(posedge clk) disable iff (rst)
    (host_lock && !cm_wr_en && blk_go) |=> !cm_wr_en);

  a_r9_lock_covers_write: assert property (@(posedge clk) disable iff (rst)
    cm_wr_en |-> host_lock);

  a_r10_word_steady: assert property (@(posedge clk) disable iff (rst)
    cm_wr_en |=> (!cm_wr_en || $stable(cm_wr_data)));
endmodule

bind cm_block_init cm_block_init_chk #(
  .AW     ($clog2(STREAMS) + $clog2(CHANNELS)),
  .WORD_W (WORD_W),
  .PAT_W  (PAT_W),
  .TOTAL  (STREAMS * CHANNELS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .blk_en     (blk_en),
  .blk_go     (blk_go),
  .mem_grant  (mem_grant),
  .cm_wr_en   (cm_wr_en),
  .cm_wr_addr (cm_wr_addr),
  .cm_wr_data (cm_wr_data),
  .fill_done  (fill_done),
  .host_lock  (host_lock)
);

// File: tb/sim_cm_block_init.sv
`timescale 1ns/1ps
module sim_cm_block_init;
  localparam int TOTAL = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_en = 1'b0;
  logic        blk_go = 1'b0;
  logic [2:0]  fill_pat = 3'd0;
  logic        mem_grant = 1'b1;
  logic        cm_wr_en;
  logic [10:0] cm_wr_addr;
  logic [11:0] cm_wr_data;
  logic        fill_done;
  logic        host_lock;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int grant_mode = 0;
  bit cmp_on = 1'b0;

  // behavioural reference
  int m_st = 0;
  int m_wr = 0;
  int m_addr = 0;
  int m_data = 0;
  int m_done = 0;
  int m_lock = 0;
  int granted = 0;

  cm_block_init u0 (
    .clk(clk), .rst(rst), .blk_en(blk_en), .blk_go(blk_go),
    .fill_pat(fill_pat), .mem_grant(mem_grant),
    .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data),
    .fill_done(fill_done), .host_lock(host_lock)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycle);
    end
  endtask

  // reference model updated at each edge from the inputs held since the last falling edge
  always @(posedge clk) begin
    cycle++;
    if (rst) begin
      m_st = 0; m_wr = 0; m_addr = 0; m_data = 0; m_done = 0; m_lock = 0;
    end else begin
      if (m_wr == 1 && mem_grant) granted++;
      case (m_st)
        0: if (blk_en && blk_go) begin
             m_st = 1; m_wr = 1; m_addr = 0; m_data = int'(fill_pat); m_lock = 1;
           end
        1: if (!(blk_en && blk_go)) begin
             m_wr = 0;
             if (blk_go) m_st = 2;
             else begin m_st = 0; m_lock = 0; end
           end else if (mem_grant) begin
             if (m_addr == TOTAL - 1) begin m_wr = 0; m_done = 1; m_st = 2; end
             else m_addr++;
           end
        default: if (!blk_go) begin m_st = 0; m_done = 0; m_lock = 0; end
      endcase
    end
  end

  // grant pattern and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    case (grant_mode)
      0: mem_grant <= 1'b1;
      1: mem_grant <= (cycle % 3) != 0;
      default: mem_grant <= ((cycle * 7) % 5) < 2;
    endcase
    if (cmp_on) begin
      check("R2/R7", "cm_wr_en", int'(cm_wr_en), m_wr);
      check("R5/R6", "fill_done", int'(fill_done), m_done);
      check("R8/R9", "host_lock", int'(host_lock), m_lock);
      if (m_wr == 1) begin
        check("R4", "cm_wr_addr", int'(cm_wr_addr), m_addr);
        check("R10", "cm_wr_data", int'(cm_wr_data), m_data);
        check("R3", "upper word bits", int'(cm_wr_data[11:3]), 0);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      if (fill_done) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    wait (cycle > 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected<=150000", cycle);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int g0;
    wait_cyc(3);
    // R1: state during reset, after edges with rst high
    check("R1", "wr_en in reset", int'(cm_wr_en), 0);
    check("R1", "done in reset", int'(fill_done), 0);
    check("R1", "lock in reset", int'(host_lock), 0);
    check("R1", "addr in reset", int'(cm_wr_addr), 0);
    check("R1", "data in reset", int'(cm_wr_data), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    wait_cyc(1);
    check("R1", "wr_en after reset", int'(cm_wr_en), 0);

    // R2: either bit alone does nothing
    blk_en = 1'b1; wait_cyc(5);
    check("R2", "enable alone", int'(cm_wr_en), 0);
    blk_en = 1'b0; blk_go = 1'b1; wait_cyc(5);
    check("R2", "go alone", int'(cm_wr_en), 0);
    blk_go = 1'b0; wait_cyc(2);

    // full fill, grant always, pattern changed mid-fill (R5, R10)
    g0 = granted;
    fill_pat = 3'd5; blk_en = 1'b1; blk_go = 1'b1;
    wait_cyc(1);
    check("R2", "first write strobe", int'(cm_wr_en), 1);
    check("R2", "first write addr", int'(cm_wr_addr), 0);
    wait_cyc(100);
    fill_pat = 3'd2;
    wait_cyc(10);
    check("R10", "data after pattern change", int'(cm_wr_data), 5);
    wait_done();
    check("R5", "granted writes in full fill", granted - g0, TOTAL);
    check("R5", "done after full fill", int'(fill_done), 1);
    wait_cyc(6);
    check("R6", "done held while go high", int'(fill_done), 1);
    blk_go = 1'b0;
    wait_cyc(1);
    check("R6", "done after go low", int'(fill_done), 0);
    check("R6", "lock after go low", int'(host_lock), 0);
    blk_en = 1'b0; wait_cyc(2);

    // stalled grant, stop through go (R4, R7, R9)
    grant_mode = 1;
    fill_pat = 3'd3; blk_en = 1'b1; blk_go = 1'b1;
    wait_cyc(300);
    blk_go = 1'b0;
    wait_cyc(1);
    check("R7", "strobe after go stop", int'(cm_wr_en), 0);
    check("R9", "lock after go stop", int'(host_lock), 0);
    wait_cyc(5);
    check("R7", "no write after stop", int'(cm_wr_en), 0);
    check("R7", "done after stop", int'(fill_done), 0);

    // stop through enable, go kept high (R8)
    fill_pat = 3'd7; blk_go = 1'b1;
    wait_cyc(200);
    blk_en = 1'b0;
    wait_cyc(1);
    check("R7", "strobe after enable stop", int'(cm_wr_en), 0);
    check("R8", "lock held after enable stop", int'(host_lock), 1);
    blk_en = 1'b1;
    wait_cyc(8);
    check("R8", "no restart while go high", int'(cm_wr_en), 0);
    blk_go = 1'b0;
    wait_cyc(1);
    check("R8", "lock after go low", int'(host_lock), 0);
    blk_go = 1'b1;
    wait_cyc(1);
    check("R2", "restart at address 0", int'(cm_wr_addr), 0);
    check("R2", "restart strobe", int'(cm_wr_en), 1);

    // complete that fill under an irregular grant (R4, R5)
    g0 = granted;
    grant_mode = 2;
    wait_done();
    check("R5", "granted writes with stalls", granted - g0, TOTAL);
    blk_go = 1'b0; blk_en = 1'b0;
    wait_cyc(4);
    check("R6", "idle at end", int'(host_lock), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule